// File: doc/BRIEF.md
# Four-Channel DMA Engine with Audio FIFO Refill

This block moves data between two addresses on a shared bus on behalf of four independent channels. Each channel is programmed with a source address, a destination address, a unit count and a control word. The control word selects when the channel starts: at once, on a vertical-blank strobe, on a horizontal-blank strobe, or in a special mode. One unit moves per step. A step is a single bus read of the source followed by a single bus write of the destination. The unit is 16 or 32 bits wide, and both addresses then move according to their adjust modes.

On channels 1 and 2, the special mode serves an audio sample FIFO. When a refill request arrives whose address matches the channel's programmed destination, the channel sends a burst of four 32-bit words to that one fixed address. It then waits for the next request. When more than one channel is ready, a fixed priority picks which one runs the next step, and the lowest channel number wins.

Software-side setup arrives over a simple write port. The blanking strobes and refill requests are single-cycle pulses. The bus side is a valid/ready request port. Once `bus_valid` is raised, the engine holds the address, direction, width and write data steady until `bus_ready` is seen high at a clock edge. The bus slave may hold `bus_ready` low for any number of cycles, and the engine simply waits.

Top module: `quad_dma`

## Requirements
- R1: After reset, no channel is running (`ch_active` = 0), `bus_valid` is low, and all programmed and working registers are zero.
- R2: Setup port encoding: `cfg_sel` 0 writes the source address, 1 the destination address, 2 the count, and 3 the control word. In the control word, bit 0 is enable, bit 1 is wide (32-bit), bit 2 is repeat, bits 4:3 are start timing (0 now, 1 vertical blank, 2 horizontal blank, 3 special), bits 6:5 are source adjust, and bits 8:7 are destination adjust. Adjust codes are 0 increment, 1 decrement, 2 fixed, and 3 increment-with-reload.
- R3: When enable goes from 0 to 1, the working addresses and count are loaded from the programmed values. A programmed count of 0 loads the maximum: 16383 on channels 0–2 and 65535 on channel 3. With timing 0, the channel runs at once. Writing enable = 0 stops the channel.
- R4: Each step reads the source and then writes the read data to the destination. The step moves 32 bits when wide is set, otherwise 16 bits. Each address then moves by the unit size in bytes according to its adjust code. Source code 3 is illegal and leaves the source address unchanged. Destination code 3 increments.
- R5: The run flag clears when the count reaches zero. If repeat is clear (and the channel is not in FIFO mode), the enable bit also clears, so later strobes start nothing.
- R6: A vertical-blank strobe starts an enabled, idle channel with timing 1. A horizontal-blank strobe does the same for timing 2. A strobe arriving while the channel is already running is ignored.
- R7: When a repeating channel is restarted by a strobe, its count is reloaded from the programmed value. If the destination adjust code is 3, the destination is also reloaded from the programmed value.
- R8: A refill request starts channel 1 or 2 only if that channel is enabled, its timing is 3, and its programmed destination equals `fifo_addr`. The channel then runs 4 units, each 32 bits wide whatever the wide bit says, with the destination held fixed. Repeat is forced on, so the channel stays enabled. Channels 0 and 3 ignore refill requests.
- R9: When several channels are running, the next step goes to the lowest-numbered running channel.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr`, `bus_wide` and `bus_wdata` stay unchanged. A read accepted by the slave is followed directly by the write of the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | 2 | Channel addressed by the setup write |
| cfg_sel | input | 2 | Register selected by the setup write |
| cfg_wdata | input | 32 | Setup write data |
| vblank | input | 1 | Vertical-blank strobe |
| hblank | input | 1 | Horizontal-blank strobe |
| fifo_req | input | 1 | Audio FIFO refill request strobe |
| fifo_addr | input | 32 | Address of the FIFO asking for data |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_wide | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Write data (the data read in the same step) |
| bus_ready | input | 1 | Slave accepts the current request |
| bus_rdata | input | 32 | Read data, taken when a read is accepted |
| ch_active | output | 4 | Per-channel run flags |

## Verification
The hardest situations to reach from the ports are a strobe that lands while its channel is in the middle of a burst, and a repeat restart that must reload a destination address which has already moved away. The stimulus programs a repeating channel with the reload destination code and fires a second vertical blank a few cycles after the first, while units are still in flight. A later strobe then restarts the channel, and the destination address seen on the bus shows whether it went back to its programmed value. The 16-bit count of channel 3 is only visible after more than 16383 units, so a long run with the slave always ready checks that this channel is still busy beyond that point.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

  // Address adjust codes (control bits 6:5 source, 8:7 destination)
  typedef enum logic [1:0] {
    ADJ_INC = 2'd0,
    ADJ_DEC = 2'd1,
    ADJ_FIX = 2'd2,
    ADJ_RLD = 2'd3
  } adj_e;

  // Start timing codes (control bits 4:3)
  typedef enum logic [1:0] {
    TM_NOW = 2'd0,
    TM_VBL = 2'd1,
    TM_HBL = 2'd2,
    TM_SPC = 2'd3
  } timing_e;

  // Control word, MSB first: dst_adj, src_adj, timing, rpt, wide, enable
  typedef struct packed {
    adj_e    dst_adj;
    adj_e    src_adj;
    timing_e timing;
    logic    rpt;
    logic    wide;
    logic    enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } step_st_e;

endpackage

// File: rtl/qdma_prio.sv
module qdma_prio #(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input  logic [NCH-1:0]   req,
  output logic             any,
  output logic [SEL_W-1:0] idx
);

  // Scan from the top so that the lowest requesting channel wins.
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = SEL_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
  import qdma_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CNT_W   = 14,
  parameter bit FIFO_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_src,
  input  logic          wr_dst,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic [AW-1:0] wdata,
  input  logic          vblank,
  input  logic          hblank,
  input  logic          fifo_req,
  input  logic [AW-1:0] fifo_addr,
  input  logic          step_me,
  output logic          active,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic          wide_eff
);

  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] FIFO_WORDS = CNT_W'(4);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  ctrl_t            ctl;
  ctrl_t            new_ctl;
  logic [AW-1:0]    prog_src;
  logic [AW-1:0]    prog_dst;
  logic [CNT_W-1:0] prog_cnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] init_cnt;
  logic [AW-1:0]    stride;
  logic             fifo_mode;
  logic             blank_hit;
  logic             fifo_hit;
  logic             en_rise;
  logic             last_unit;

  assign new_ctl   = ctrl_t'(wdata[CTRL_W-1:0]);
  assign fifo_mode = FIFO_OK && (ctl.timing == TM_SPC);
  assign wide_eff  = ctl.wide | fifo_mode;
  assign stride    = wide_eff ? AW'(4) : AW'(2);
  assign init_cnt  = (prog_cnt == '0) ? CNT_MAX : prog_cnt;
  assign last_unit = (cnt == CNT_ONE);
  assign blank_hit = !active && ctl.enable &&
                     ((vblank && ctl.timing == TM_VBL) ||
                      (hblank && ctl.timing == TM_HBL));
  assign fifo_hit  = FIFO_OK && fifo_req && ctl.enable &&
                     (ctl.timing == TM_SPC) && (prog_dst == fifo_addr);
  assign en_rise   = wr_ctl && new_ctl.enable && !ctl.enable;

  // Later assignments in this block take precedence:
  // step completion, then triggers, then setup writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      prog_src <= '0;
      prog_dst <= '0;
      prog_cnt <= '0;
      cnt      <= '0;
      cur_src  <= '0;
      cur_dst  <= '0;
      active   <= 1'b0;
    end else begin
      if (step_me && active) begin
        case (ctl.src_adj)
          ADJ_INC: cur_src <= cur_src + stride;
          ADJ_DEC: cur_src <= cur_src - stride;
          default: ;  // fixed, and the illegal code, hold the source
        endcase
        if (!fifo_mode) begin
          case (ctl.dst_adj)
            ADJ_INC, ADJ_RLD: cur_dst <= cur_dst + stride;
            ADJ_DEC:          cur_dst <= cur_dst - stride;
            default: ;
          endcase
        end
        cnt <= cnt - CNT_ONE;
        if (last_unit) begin
          active <= 1'b0;
          if (!ctl.rpt && !fifo_mode) ctl.enable <= 1'b0;
        end
      end

      if (blank_hit) begin
        active <= 1'b1;
        if (ctl.rpt) begin
          cnt <= init_cnt;
          if (ctl.dst_adj == ADJ_RLD) cur_dst <= prog_dst;
        end
      end

      if (fifo_hit) begin
        active  <= 1'b1;
        cnt     <= FIFO_WORDS;
        ctl.rpt <= 1'b1;
      end

      if (wr_src) prog_src <= wdata;
      if (wr_dst) prog_dst <= wdata;
      if (wr_cnt) prog_cnt <= wdata[CNT_W-1:0];
      if (wr_ctl) begin
        ctl <= new_ctl;
        if (en_rise) begin
          cur_src <= prog_src;
          cur_dst <= prog_dst;
          cnt     <= init_cnt;
          active  <= (new_ctl.timing == TM_NOW);
        end else if (!new_ctl.enable) begin
          active <= 1'b0;
        end
      end
    end
  end

  assert_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_me && active && ctl.src_adj == ADJ_RLD && !wr_ctl) |=> $stable(cur_src));

  assert_fifo_dst_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_me && active && fifo_mode && !wr_ctl) |=> $stable(cur_dst));

  assert_last_unit_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_me && active && cnt == CNT_ONE && !fifo_hit && !wr_ctl) |=> !active);

  assert_strobe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (vblank || hblank) && !step_me && !fifo_hit && !wr_ctl)
      |=> (active && $stable(cnt) && $stable(cur_dst)));

endmodule

// File: rtl/qdma_step_fsm.sv
module qdma_step_fsm
  import qdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic [SEL_W-1:0] pick,
  input  logic [AW-1:0]    src_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic             wide_in,
  output logic [SEL_W-1:0] sel,
  output logic             bus_valid,
  output logic             bus_write,
  output logic             bus_wide,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ready,
  input  logic [DW-1:0]    bus_rdata,
  output logic             step_done
);

  step_st_e      state;
  logic [DW-1:0] data_q;

  // The channel is chosen in IDLE and held for the whole step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sel    <= '0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (any_req) begin
            sel   <= pick;
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (bus_ready) begin
            data_q <= bus_rdata;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (bus_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid = (state != ST_IDLE);
  assign bus_write = (state == ST_WRITE);
  assign bus_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
  assign bus_wide  = wide_in;
  assign bus_wdata = data_q;
  assign step_done = (state == ST_WRITE) && bus_ready;

  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) &&
      $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wide)));

  assert_read_then_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_ready) |=> (bus_valid && bus_write));

endmodule

// File: rtl/quad_dma.sv
module quad_dma
  import qdma_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CNT_W      = 14,
  parameter int LAST_CNT_W = 16,
  parameter int FIFO_LO    = 1,
  parameter int FIFO_HI    = 2,
  localparam int SEL_W     = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             vblank,
  input  logic             hblank,
  input  logic             fifo_req,
  input  logic [AW-1:0]    fifo_addr,
  output logic             bus_valid,
  output logic             bus_write,
  output logic             bus_wide,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ready,
  input  logic [DW-1:0]    bus_rdata,
  output logic [NCH-1:0]   ch_active
);

  logic [AW-1:0]    src_v [NCH];
  logic [AW-1:0]    dst_v [NCH];
  logic [NCH-1:0]   wide_v;
  logic             any_req;
  logic [SEL_W-1:0] pick;
  logic [SEL_W-1:0] sel;
  logic             step_done;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int CW  = (g == NCH - 1) ? LAST_CNT_W : CNT_W;
    localparam bit FOK = (g >= FIFO_LO) && (g <= FIFO_HI);
    logic hit;
    assign hit = cfg_we && (cfg_ch == SEL_W'(g));

    qdma_channel #(
      .AW     (AW),
      .CNT_W  (CW),
      .FIFO_OK(FOK)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_src   (hit && cfg_sel == 2'd0),
      .wr_dst   (hit && cfg_sel == 2'd1),
      .wr_cnt   (hit && cfg_sel == 2'd2),
      .wr_ctl   (hit && cfg_sel == 2'd3),
      .wdata    (cfg_wdata),
      .vblank   (vblank),
      .hblank   (hblank),
      .fifo_req (fifo_req),
      .fifo_addr(fifo_addr),
      .step_me  (step_done && sel == SEL_W'(g)),
      .active   (ch_active[g]),
      .cur_src  (src_v[g]),
      .cur_dst  (dst_v[g]),
      .wide_eff (wide_v[g])
    );
  end

  qdma_prio #(
    .NCH  (NCH),
    .SEL_W(SEL_W)
  ) u_prio (
    .req(ch_active),
    .any(any_req),
    .idx(pick)
  );

  qdma_step_fsm #(
    .AW   (AW),
    .DW   (DW),
    .SEL_W(SEL_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_req  (any_req),
    .pick     (pick),
    .src_addr (src_v[sel]),
    .dst_addr (dst_v[sel]),
    .wide_in  (wide_v[sel]),
    .sel      (sel),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_wide (bus_wide),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ready(bus_ready),
    .bus_rdata(bus_rdata),
    .step_done(step_done)
  );

  // A step that starts must belong to the lowest channel that was running.
  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && |ch_active) |=>
      ((NCH'(1) << sel) == ($past(ch_active) & ~($past(ch_active) - NCH'(1)))));

endmodule

// File: tb/quad_dma_tb.sv
`timescale 1ns/1ps
module quad_dma_tb;

  localparam logic [31:0] MAGIC = 32'hC3C3_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        vblank = 1'b0;
  logic        hblank = 1'b0;
  logic        fifo_req = 1'b0;
  logic [31:0] fifo_addr = '0;
  logic        bus_valid, bus_write, bus_wide;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic [3:0]  ch_active;

  always #2 clk = ~clk;

  assign bus_rdata = bus_addr ^ MAGIC;

  quad_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .vblank(vblank), .hblank(hblank), .fifo_req(fifo_req),
    .fifo_addr(fifo_addr), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .ch_active(ch_active)
  );

  int    total = 0;
  int    bad = 0;
  int    writes = 0;
  bit    rnd_ready = 0;
  bit    done = 0;
  string phase = "R1";
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_rd_addr = '0;
  bit          last_wr_wide = 0;
  logic [31:0] wlog[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_st = 0;
  int          m_sel = 0;
  logic [31:0] m_data = '0;
  logic [31:0] p_src[4], p_dst[4], c_src[4], c_dst[4];
  int          p_cnt[4], c_cnt[4];
  logic [8:0]  m_ctl[4];
  bit          m_act[4];

  function automatic int maxc(input int i);
    return (i == 3) ? 65535 : 16383;
  endfunction
  function automatic bit fok(input int i);
    return (i == 1) || (i == 2);
  endfunction
  function automatic int initc(input int i);
    return (p_cnt[i] == 0) ? maxc(i) : p_cnt[i];
  endfunction
  function automatic logic [31:0] mk(input int en, input int wide, input int rpt,
                                     input int tm, input int sa, input int da);
    return 32'(en | (wide << 1) | (rpt << 2) | (tm << 3) | (sa << 5) | (da << 7));
  endfunction

  task automatic model_edge();
    bit          oa[4];
    logic [8:0]  oc[4];
    logic [31:0] opd[4];
    int          step;
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_data = '0;
      for (int i = 0; i < 4; i++) begin
        p_src[i] = '0; p_dst[i] = '0; c_src[i] = '0; c_dst[i] = '0;
        p_cnt[i] = 0; c_cnt[i] = 0; m_ctl[i] = '0; m_act[i] = 0;
      end
      return;
    end
    for (int i = 0; i < 4; i++) begin
      oa[i] = m_act[i]; oc[i] = m_ctl[i]; opd[i] = p_dst[i];
    end
    step = -1;
    case (m_st)
      0: begin
        for (int i = 3; i >= 0; i--) if (oa[i]) m_sel = i;
        if (oa[0] || oa[1] || oa[2] || oa[3]) m_st = 1;
      end
      1: if (bus_ready) begin m_data = c_src[m_sel] ^ MAGIC; m_st = 2; end
      default: if (bus_ready) begin step = m_sel; m_st = 0; end
    endcase
    for (int i = 0; i < 4; i++) begin
      bit fm;
      int sz;
      fm = fok(i) && oc[i][4:3] == 2'd3;
      sz = (oc[i][1] || fm) ? 4 : 2;
      if (step == i && oa[i]) begin
        if (oc[i][6:5] == 2'd0) c_src[i] = c_src[i] + 32'(sz);
        else if (oc[i][6:5] == 2'd1) c_src[i] = c_src[i] - 32'(sz);
        if (!fm) begin
          if (oc[i][8:7] == 2'd0 || oc[i][8:7] == 2'd3) c_dst[i] = c_dst[i] + 32'(sz);
          else if (oc[i][8:7] == 2'd1) c_dst[i] = c_dst[i] - 32'(sz);
        end
        c_cnt[i]--;
        if (c_cnt[i] == 0) begin
          m_act[i] = 0;
          if (!oc[i][2] && !fm) m_ctl[i][0] = 1'b0;
        end
      end
      if (!oa[i] && oc[i][0] && ((vblank && oc[i][4:3] == 2'd1) ||
                                  (hblank && oc[i][4:3] == 2'd2))) begin
        m_act[i] = 1;
        if (oc[i][2]) begin
          c_cnt[i] = initc(i);
          if (oc[i][8:7] == 2'd3) c_dst[i] = opd[i];
        end
      end
      if (fok(i) && fifo_req && oc[i][0] && oc[i][4:3] == 2'd3 && opd[i] == fifo_addr) begin
        m_act[i] = 1; c_cnt[i] = 4; m_ctl[i][2] = 1'b1;
      end
      if (cfg_we && int'(cfg_ch) == i) begin
        case (cfg_sel)
          2'd0: p_src[i] = cfg_wdata;
          2'd1: p_dst[i] = cfg_wdata;
          2'd2: p_cnt[i] = int'(cfg_wdata) & maxc(i);
          default: begin
            if (cfg_wdata[0] && !oc[i][0]) begin
              c_src[i] = p_src[i]; c_dst[i] = p_dst[i]; c_cnt[i] = initc(i);
              m_act[i] = (cfg_wdata[4:3] == 2'd0);
            end else if (!cfg_wdata[0]) begin
              m_act[i] = 0;
            end
            m_ctl[i] = cfg_wdata[8:0];
          end
        endcase
      end
    end
  endtask

  // Model advances on each edge; outputs compared 1 ns later.
  always @(posedge clk) begin
    bit          ev;
    logic [31:0] ea;
    bit          ew;
    logic [3:0]  eact;
    model_edge();
    #1;
    if (rst_n && !done) begin
      ev = (m_st != 0);
      eact = {m_act[3], m_act[2], m_act[1], m_act[0]};
      chk(ch_active == eact, {phase, " run flags"}, ch_active, eact);
      chk(bus_valid == ev, {phase, " R10 valid"}, bus_valid, ev);
      if (ev && bus_valid) begin
        ea = (m_st == 2) ? c_dst[m_sel] : c_src[m_sel];
        ew = m_ctl[m_sel][1] || (fok(m_sel) && m_ctl[m_sel][4:3] == 2'd3);
        chk(bus_write == (m_st == 2), {phase, " R10 direction"}, bus_write, m_st == 2);
        chk(bus_addr == ea, {phase, " R4 address"}, bus_addr, ea);
        chk(bus_wide == ew, {phase, " R4 width"}, bus_wide, ew);
        if (m_st == 2) chk(bus_wdata == m_data, {phase, " R4 data"}, bus_wdata, m_data);
      end
      if (bus_valid && bus_ready) begin
        if (bus_write) begin
          writes++; last_wr_addr = bus_addr; last_wr_wide = bus_wide;
          wlog.push_back(bus_addr);
        end else begin
          last_rd_addr = bus_addr;
        end
      end
    end
  end

  // Slave ready pattern
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog %s actual=timeout expected=finish", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cfg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_v();
    @(negedge clk); vblank = 1'b1; @(negedge clk); vblank = 1'b0;
  endtask
  task automatic pulse_h();
    @(negedge clk); hblank = 1'b1; @(negedge clk); hblank = 1'b0;
  endtask
  task automatic refill(input logic [31:0] a);
    @(negedge clk); fifo_req = 1'b1; fifo_addr = a; @(negedge clk); fifo_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (ch_active != 0 || bus_valid) @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, 32'(n));
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(ch_active == 4'd0, "R1 reset run flags", ch_active, 0);
    chk(bus_valid == 1'b0, "R1 reset valid", bus_valid, 0);
    rst_n = 1'b1;

    // R2 / R4: immediate, 32-bit, increment both
    phase = "R2";
    setup(0, 32'h1000, 32'h2000, 5);
    base = writes;
    cfg(0, 3, mk(1, 1, 0, 0, 0, 0));
    wait_idle();
    chk(writes - base == 5, "R2 unit count", writes - base, 5);
    chk(last_wr_addr == 32'h2010, "R4 increment dst", last_wr_addr, 32'h2010);

    // R4 / R10: 16-bit, decrement source, fixed dst, stalling slave
    phase = "R10"; rnd_ready = 1;
    setup(3, 32'h3000, 32'h4000, 3);
    base = writes;
    cfg(3, 3, mk(1, 0, 0, 0, 1, 2));
    wait_idle();
    chk(writes - base == 3, "R10 units under stall", writes - base, 3);
    chk(last_rd_addr == 32'h2FFC, "R4 decrement src", last_rd_addr, 32'h2FFC);

    // R4: illegal source code holds the source
    phase = "R4";
    setup(2, 32'h5000, 32'h6000, 3);
    cfg(2, 3, mk(1, 1, 0, 0, 3, 1));
    wait_idle();
    chk(last_rd_addr == 32'h5000, "R4 src code 3 held", last_rd_addr, 32'h5000);
    chk(last_wr_addr == 32'h5FF8, "R4 decrement dst", last_wr_addr, 32'h5FF8);
    rnd_ready = 0;

    // R6 / R7: vertical blank, repeat, reload destination
    phase = "R6";
    setup(1, 32'h7000, 32'h8000, 2);
    cfg(1, 3, mk(1, 1, 1, 1, 0, 3));
    repeat (4) @(negedge clk);
    chk(ch_active == 4'd0, "R6 waits for strobe", ch_active, 0);
    base = writes;
    pulse_h();
    repeat (4) @(negedge clk);
    chk(writes == base, "R6 wrong strobe ignored", writes - base, 0);
    pulse_v();
    pulse_v();  // arrives while running: ignored
    wait_idle();
    chk(writes - base == 2, "R6 strobe while running ignored", writes - base, 2);
    phase = "R7";
    pulse_v();
    wait_idle();
    chk(writes - base == 4, "R7 repeat restart count", writes - base, 4);
    chk(last_wr_addr == 32'h8004, "R7 dst reloaded", last_wr_addr, 32'h8004);
    cfg(1, 3, 32'h0);

    // R5: non-repeat horizontal blank clears enable
    phase = "R5";
    setup(2, 32'h9000, 32'hA000, 1);
    cfg(2, 3, mk(1, 0, 0, 2, 0, 0));
    base = writes;
    pulse_h();
    wait_idle();
    chk(writes - base == 1, "R5 single unit", writes - base, 1);
    pulse_h();
    repeat (6) @(negedge clk);
    chk(writes - base == 1, "R5 enable cleared", writes - base, 1);
    chk(ch_active == 4'd0, "R5 run flag clear", ch_active, 0);

    // R8: FIFO refill
    phase = "R8";
    setup(1, 32'hB000, 32'h100, 9);
    cfg(1, 3, mk(1, 0, 0, 3, 0, 0));
    setup(0, 32'hC000, 32'h100, 9);
    cfg(0, 3, mk(1, 0, 0, 3, 0, 0));
    base = writes;
    refill(32'h104);
    repeat (6) @(negedge clk);
    chk(writes == base, "R8 address mismatch ignored", writes - base, 0);
    refill(32'h100);
    wait_idle();
    chk(writes - base == 4, "R8 four words", writes - base, 4);
    chk(last_wr_addr == 32'h100, "R8 fixed dst", last_wr_addr, 32'h100);
    chk(last_wr_wide == 1'b1, "R8 forced 32-bit", last_wr_wide, 1);
    refill(32'h100);
    wait_idle();
    chk(writes - base == 8, "R8 stays armed, ch0 ignores", writes - base, 8);
    cfg(0, 3, 32'h0);
    cfg(1, 3, 32'h0);

    // R9: lowest channel wins
    phase = "R9";
    setup(3, 32'hE300, 32'hD300, 1);
    setup(2, 32'hE200, 32'hD200, 1);
    setup(0, 32'hE000, 32'hD000, 1);
    cfg(3, 3, mk(1, 1, 0, 1, 0, 0));
    cfg(2, 3, mk(1, 1, 0, 1, 0, 0));
    cfg(0, 3, mk(1, 1, 0, 1, 0, 0));
    wlog.delete();
    pulse_v();
    wait_idle();
    chk(wlog.size() == 3, "R9 three units", wlog.size(), 3);
    if (wlog.size() == 3) begin
      chk(wlog[0] == 32'hD000, "R9 first ch0", wlog[0], 32'hD000);
      chk(wlog[1] == 32'hD200, "R9 then ch2", wlog[1], 32'hD200);
      chk(wlog[2] == 32'hD300, "R9 then ch3", wlog[2], 32'hD300);
    end
    wlog.delete();

    // R3: zero count loads the maximum
    phase = "R3";
    setup(0, 32'h0, 32'h10000, 0);
    base = writes;
    cfg(0, 3, mk(1, 0, 0, 0, 0, 0));
    wait_idle();
    chk(writes - base == 16383, "R3 ch0 max count", writes - base, 16383);
    wlog.delete();
    setup(3, 32'h0, 32'h40000, 0);
    base = writes;
    cfg(3, 3, mk(1, 0, 0, 0, 0, 0));
    while (writes - base < 16400) @(negedge clk);
    chk(ch_active[3] == 1'b1, "R3 ch3 wider count", ch_active[3], 1);
    cfg(3, 3, 32'h0);
    wait_idle();
    chk(ch_active == 4'd0, "R3 disable stops", ch_active, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule